// File: doc/BRIEF.md
# Monotonic Stream-Synchronised Wall Clock

This block keeps a 64-bit wall-clock register that only moves forward once every active audio stream has caught up with the time being requested. A request arrives as a one-cycle strobe with a value and a force flag. Alongside it come the absolute elapsed positions of the front output stream, the line-input stream and, when a parameter enables it, the microphone-input stream.

A plain request is taken only when all active streams have reached the requested time. The register then loads the largest of the requested value and all stream positions. A forced request loads the requested value exactly, whatever the streams report.

One cycle after each request, the block reports whether the clock now equals the requested value ("updated") or not ("delayed"). It also flags two conditions. The first is an attempt to move the clock backwards, which raises an error. The second is a run of requests that leave the value unchanged, which raises a stale warning. The clock output is valid in every cycle.

Top module: `wallclock_sync`

## Requirements
- R1: A non-forced request is accepted only when each active stream position is greater than or equal to the requested value. Otherwise the clock keeps its value.
- R2: An accepted non-forced request loads the maximum of the requested value and all active stream positions.
- R3: A forced request loads exactly the requested value, whatever the stream positions are, including a value below the current clock.
- R4: With `MIC_EN` = 1 the microphone position both gates and contributes to the maximum. With `MIC_EN` = 0 the microphone position is ignored completely.
- R5: If an accepted non-forced request computes a value below the current clock, the clock is kept. In that case `backwardErr` goes high and stays high until reset.
- R6: An accepted non-forced request whose computed value equals the current clock increments a saturating stale counter. `staleWarn` is high while that counter exceeds `STALE_LIMIT` (default 3), so it rises on the 4th such request in a row. Any load that changes the clock value, forced or not, clears the counter and the warning. A forced load of an equal value leaves the counter unchanged.
- R7: `resultValid` is high exactly in the cycle after a request strobe. `resultUpdated` is then 1 when the clock after the request equals the requested value, and 0 otherwise.
- R8: A synchronous reset clears the clock, the stale counter, `staleWarn`, `backwardErr` and `resultValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Set-request strobe, one request per cycle |
| reqForce | input | 1 | Load the requested value unconditionally |
| reqValue | input | W | Requested wall-clock value |
| frontPos | input | W | Absolute elapsed position of the front output stream |
| lineInPos | input | W | Absolute elapsed position of the line-input stream |
| micPos | input | W | Absolute elapsed position of the microphone stream (used when MIC_EN=1) |
| clockValue | output | W | Current wall-clock value |
| resultValid | output | 1 | Result of the previous cycle's request is present |
| resultUpdated | output | 1 | 1 = clock equals the requested value, 0 = delayed |
| staleWarn | output | 1 | Repeated non-advancing updates |
| backwardErr | output | 1 | Sticky: a non-forced update would have moved the clock back |

## Verification
The two flags are the hardest states to reach from the ports. The backward error can only occur after a forced request has pushed the clock above every stream position. A plain request whose streams all sit below that forced value is then applied. The stale warning needs four consecutive accepted plain requests whose stream maximum equals the current clock, with no value-changing load in between. The stimulus builds exactly these sequences. It also checks that a forced load of the same value neither clears nor advances the warning.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  typedef struct packed {
    logic loadMax;     // accepted plain request: load running maximum
    logic loadReq;     // forced request: load requested value
    logic takeResult;  // capture result of this request
  } wclkStrobes_t;
endpackage

// File: rtl/wclk_ctrl.sv
module wclk_ctrl
  import wclk_pkg::*;
#(
  parameter int STALE_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqForce,
  input  logic         allPassed,
  input  logic         maxBelowClock,
  input  logic         maxEqClock,
  input  logic         reqEqClock,
  output wclkStrobes_t strobes,
  output logic         staleWarn,
  output logic         backwardErr
);
  localparam int CNT_MAX = STALE_LIMIT + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] staleCnt;
  logic             plainOk;
  logic             wouldGoBack;

  always_comb begin
    plainOk            = reqValid && !reqForce && allPassed;
    wouldGoBack        = plainOk && maxBelowClock;
    strobes.loadReq    = reqValid && reqForce;
    strobes.loadMax    = plainOk && !maxBelowClock;
    strobes.takeResult = reqValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staleCnt <= '0;
    end else if (strobes.loadMax && maxEqClock) begin
      if (staleCnt != CNT_W'(CNT_MAX)) staleCnt <= staleCnt + 1'b1;
    end else if (strobes.loadMax || (strobes.loadReq && !reqEqClock)) begin
      staleCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              backwardErr <= 1'b0;
    else if (wouldGoBack) backwardErr <= 1'b1;
  end

  assign staleWarn = (staleCnt > CNT_W'(STALE_LIMIT));

  // R5: error flag is sticky until reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    backwardErr |=> backwardErr);
  // R6: a value-changing plain load clears the warning
  a_r6_clear_on_change: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadMax && !maxEqClock) |=> !staleWarn);
  // R6: the warning only rises after a stale update
  a_r6_rise_needs_stale: assert property (@(posedge clk) disable iff (rst)
    $rose(staleWarn) |-> $past(strobes.loadMax && maxEqClock));
  // R3: forced and plain loads never coincide
  a_r3_one_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadMax, strobes.loadReq}));
endmodule

// File: rtl/wclk_datapath.sv
module wclk_datapath
  import wclk_pkg::*;
#(
  parameter int W       = 64,
  parameter int NUM_POS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  wclkStrobes_t              strobes,
  input  logic [W-1:0]              reqValue,
  input  logic [NUM_POS-1:0][W-1:0] posVec,
  output logic [W-1:0]              clockValue,
  output logic                      resultValid,
  output logic                      resultUpdated,
  output logic                      allPassed,
  output logic                      maxBelowClock,
  output logic                      maxEqClock,
  output logic                      reqEqClock
);
  logic [NUM_POS:0][W-1:0] runMax;
  logic [NUM_POS:0]        runPass;
  logic [W-1:0]            nextClock;

  assign runMax[0]  = reqValue;
  assign runPass[0] = 1'b1;

  for (genvar i = 0; i < NUM_POS; i++) begin : g_chain
    assign runMax[i+1]  = (posVec[i] > runMax[i]) ? posVec[i] : runMax[i];
    assign runPass[i+1] = runPass[i] && (posVec[i] >= reqValue);
  end

  always_comb begin
    allPassed     = runPass[NUM_POS];
    maxBelowClock = runMax[NUM_POS] < clockValue;
    maxEqClock    = runMax[NUM_POS] == clockValue;
    reqEqClock    = reqValue == clockValue;
    if (strobes.loadReq)      nextClock = reqValue;
    else if (strobes.loadMax) nextClock = runMax[NUM_POS];
    else                      nextClock = clockValue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clockValue    <= '0;
      resultValid   <= 1'b0;
      resultUpdated <= 1'b0;
    end else begin
      clockValue    <= nextClock;
      resultValid   <= strobes.takeResult;
      resultUpdated <= strobes.takeResult && (nextClock == reqValue);
    end
  end

  // R3: forced load is exact
  a_r3_force_exact: assert property (@(posedge clk) disable iff (rst)
    strobes.loadReq |=> clockValue == $past(reqValue));
  // R5: without a forced load the clock never goes back
  a_r5_monotonic: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadReq |=> clockValue >= $past(clockValue));
  // R2: a plain load reaches at least the requested value
  a_r2_at_least_req: assert property (@(posedge clk) disable iff (rst)
    strobes.loadMax |=> clockValue >= $past(reqValue));
  // R7: result present exactly one cycle after a request
  a_r7_result_timing: assert property (@(posedge clk) disable iff (rst)
    strobes.takeResult |=> resultValid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !strobes.takeResult |=> !resultValid);
endmodule

// File: rtl/wallclock_sync.sv
module wallclock_sync
  import wclk_pkg::*;
#(
  parameter int W           = 64,
  parameter int MIC_EN      = 1,
  parameter int STALE_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqForce,
  input  logic [W-1:0] reqValue,
  input  logic [W-1:0] frontPos,
  input  logic [W-1:0] lineInPos,
  input  logic [W-1:0] micPos,
  output logic [W-1:0] clockValue,
  output logic         resultValid,
  output logic         resultUpdated,
  output logic         staleWarn,
  output logic         backwardErr
);
  localparam int NUM_POS = (MIC_EN != 0) ? 3 : 2;

  logic [NUM_POS-1:0][W-1:0] posVec;
  wclkStrobes_t              strobes;
  logic allPassed, maxBelowClock, maxEqClock, reqEqClock;

  assign posVec[0] = frontPos;
  assign posVec[1] = lineInPos;
  if (MIC_EN != 0) begin : g_mic
    assign posVec[2] = micPos;
  end else begin : g_nomic
    logic [W-1:0] micUnused;
    assign micUnused = micPos;
  end

  wclk_ctrl #(.STALE_LIMIT(STALE_LIMIT)) i_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqForce(reqForce),
    .allPassed(allPassed), .maxBelowClock(maxBelowClock),
    .maxEqClock(maxEqClock), .reqEqClock(reqEqClock),
    .strobes(strobes), .staleWarn(staleWarn), .backwardErr(backwardErr)
  );

  wclk_datapath #(.W(W), .NUM_POS(NUM_POS)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .reqValue(reqValue),
    .posVec(posVec), .clockValue(clockValue), .resultValid(resultValid),
    .resultUpdated(resultUpdated), .allPassed(allPassed),
    .maxBelowClock(maxBelowClock), .maxEqClock(maxEqClock),
    .reqEqClock(reqEqClock)
  );

  // R1: a plain request with a lagging line-input stream leaves the clock alone
  a_r1_gate_line: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqForce && (lineInPos < reqValue)) |=> $stable(clockValue));
  // R1: same for the front stream
  a_r1_gate_front: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqForce && (frontPos < reqValue)) |=> $stable(clockValue));
endmodule

// File: tb/test_wallclock_sync.sv
module test_wallclock_sync;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  typedef struct packed {
    logic         frc;
    logic [W-1:0] req, f, l, m, expClk;
    logic         expUpd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'd100,  64'd150, 64'd120, 64'd130, 64'd150,  1'b0}, // R2 max
    '{1'b0, 64'd200,  64'd250, 64'd190, 64'd300, 64'd150,  1'b0}, // R1 line lags
    '{1'b0, 64'd200,  64'd250, 64'd210, 64'd199, 64'd150,  1'b0}, // R4 mic lags
    '{1'b0, 64'd220,  64'd220, 64'd220, 64'd220, 64'd220,  1'b1}, // R1 equal passes
    '{1'b1, 64'd5000, 64'd0,   64'd0,   64'd0,   64'd5000, 1'b1}, // R3 forced
    '{1'b1, 64'd40,   64'd0,   64'd0,   64'd0,   64'd40,   1'b1}, // R3 forced back
    '{1'b0, 64'd50,   64'd60,  64'd70,  64'd65,  64'd70,   1'b0}, // R2 line max
    '{1'b0, 64'd80,   64'd80,  64'd80,  64'd80,  64'd80,   1'b1}  // R7 updated
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqForce = 1'b0;
  logic [W-1:0] reqValue = '0, frontPos = '0, lineInPos = '0, micPos = '0;
  logic [W-1:0] clockValue, clockNm;
  logic resultValid, resultUpdated, staleWarn, backwardErr;
  logic rvNm, ruNm, swNm, beNm;
  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wallclock_sync i_wallclock_sync (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqForce(reqForce),
    .reqValue(reqValue), .frontPos(frontPos), .lineInPos(lineInPos),
    .micPos(micPos), .clockValue(clockValue), .resultValid(resultValid),
    .resultUpdated(resultUpdated), .staleWarn(staleWarn), .backwardErr(backwardErr)
  );

  wallclock_sync #(.MIC_EN(0)) i_wallclock_sync_nomic (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqForce(reqForce),
    .reqValue(reqValue), .frontPos(frontPos), .lineInPos(lineInPos),
    .micPos(micPos), .clockValue(clockNm), .resultValid(rvNm),
    .resultUpdated(ruNm), .staleWarn(swNm), .backwardErr(beNm)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic request(input logic frc, input logic [W-1:0] v, f, l, m);
    reqValid = 1'b1; reqForce = frc; reqValue = v;
    frontPos = f; lineInPos = l; micPos = m;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    doReset();
    // R8: reset state
    check(clockValue == 0, "R8 clock after reset", clockValue, 0);
    check(!staleWarn && !backwardErr && !resultValid, "R8 flags after reset",
          {staleWarn, backwardErr, resultValid}, 0);

    for (int i = 0; i < NV; i++) begin
      request(VECS[i].frc, VECS[i].req, VECS[i].f, VECS[i].l, VECS[i].m);
      check(clockValue == VECS[i].expClk, $sformatf("R1/R2/R3 vector %0d clock", i),
            clockValue, VECS[i].expClk);
      check(resultValid && resultUpdated == VECS[i].expUpd,
            $sformatf("R7 vector %0d result", i), {resultValid, resultUpdated},
            {1'b1, VECS[i].expUpd});
    end
    @(posedge clk); @(negedge clk);
    check(!resultValid, "R7 result drops when idle", resultValid, 0);

    // R6: stale run at clock 80
    for (int k = 1; k <= 4; k++) begin
      request(1'b0, 64'd80, 64'd80, 64'd80, 64'd80);
      check(staleWarn == (k >= 4), $sformatf("R6 stale step %0d", k), staleWarn, k >= 4);
    end
    request(1'b1, 64'd80, 64'd0, 64'd0, 64'd0);
    check(staleWarn, "R6 forced same value keeps warning", staleWarn, 1);
    request(1'b0, 64'd90, 64'd90, 64'd90, 64'd90);
    check(!staleWarn && clockValue == 90, "R6 changing load clears warning",
          {staleWarn, clockValue}, 90);

    // R5: backward attempt
    request(1'b1, 64'd1000, 64'd0, 64'd0, 64'd0);
    request(1'b0, 64'd10, 64'd50, 64'd60, 64'd70);
    check(clockValue == 1000, "R5 clock kept", clockValue, 1000);
    check(backwardErr, "R5 error raised", backwardErr, 1);
    check(resultValid && !resultUpdated, "R7 backward is delayed", resultUpdated, 0);
    request(1'b1, 64'd2000, 64'd0, 64'd0, 64'd0);
    check(backwardErr && clockValue == 2000, "R5 error sticky", backwardErr, 1);

    doReset();
    check(clockValue == 0 && !backwardErr && !staleWarn, "R8 reset clears state",
          {backwardErr, staleWarn, clockValue}, 0);

    // R4: mic lagging gates only the mic-enabled instance
    request(1'b0, 64'd10, 64'd20, 64'd30, 64'd5);
    check(clockValue == 0, "R4 mic gates", clockValue, 0);
    check(clockNm == 30, "R4 mic ignored when disabled", clockNm, 30);
    request(1'b0, 64'd10, 64'd20, 64'd30, 64'd900);
    check(clockValue == 900, "R4 mic contributes max", clockValue, 900);
    check(clockNm == 30, "R4 mic excluded from max", clockNm, 30);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule